// File: doc/BRIEF.md
# Indirect-Branch Density Comparator

This unit receives a 32-bit history vector in which each set bit marks one retired instruction that was an indirect branch. It also receives an unsigned limit. From these it computes the signed value "number of set bits minus limit" and raises a violation output when that value is above zero. A retirement stage can place one copy of the unit behind each sliding-window slot it evaluates in a cycle. A positive result then tells the stage to raise a security exception for that instruction.

The logic is purely combinational and fits in one cycle. The 32 single-bit terms and the inverted limit are all fed as operands into one tree of word-level 3:2 carry-save compressors. The "+1" that completes the two's-complement negation of the limit goes in as the carry-in of the single carry-propagate adder at the root of the tree. This removes the separate popcount adder and the comparator that would otherwise follow it.

Top module: `ib_density_diff`

## Requirements
- R1: `delta` equals the number of ones in `win_bits` minus `limit`, given as a 7-bit two's-complement value.
- R2: `over` is 1 exactly when `delta` is strictly positive. When the set-bit count equals `limit`, `over` is 0.
- R3: With `win_bits` all zeros and `limit` 0, `delta` is 0 and `over` is 0.
- R4: With `win_bits` all ones and `limit` 0, `delta` is +32 and `over` is 1.
- R5: When `limit` is larger than the count, `delta` is negative. The lowest value is -63, reached with an all-zero window and `limit` 63.
- R6: Every `limit` value from 0 to 63 gives the correct result. Outputs follow the inputs with no clock and no stored state.
- R7: Each bit position of `win_bits` counts with weight one, whatever its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| win_bits | input | 32 | Window vector; a one marks an indirect branch |
| limit | input | 6 | Unsigned threshold |
| delta | output | 7 | Signed set-bit count minus threshold |
| over | output | 1 | High when delta > 0 |

## Verification
The case hardest to reach from the ports is the exact boundary where the count equals the limit, or exceeds it by one. That is where the injected inverted limit and the final carry-in must cancel exactly, so an off-by-one in the negation shows up only there. The bench builds windows with a known number of ones at scattered positions and sets `limit` to that count, and to one below it. It also walks every limit value over random vectors and one-hot vectors at each bit position.

// File: rtl/ibd_pkg.sv
package ibd_pkg;

    localparam int DEF_BITS = 32;

    // Operand count after one row of 3:2 compressors.
    function automatic int ops_after(input int k);
        return 2 * (k / 3) + (k % 3);
    endfunction

    // Operand count after lvl rows.
    function automatic int ops_at(input int k, input int lvl);
        int n;
        n = k;
        for (int i = 0; i < lvl; i++) n = ops_after(n);
        return n;
    endfunction

    // Rows needed to reach two operands.
    function automatic int rows_for(input int k);
        int n;
        int r;
        n = k;
        r = 0;
        while (n > 2) begin
            n = ops_after(n);
            r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/ibd_csa_row.sv
module ibd_csa_row #(
    parameter int W     = 7,
    parameter int N_IN  = 33,
    parameter int N_OUT = ibd_pkg::ops_after(N_IN)
) (
    input  logic [W-1:0] in_ops  [N_IN],
    output logic [W-1:0] out_ops [N_OUT]
);
    localparam int GROUPS = N_IN / 3;
    localparam int REST   = N_IN % 3;

    for (genvar g = 0; g < GROUPS; g++) begin : g_fa
        logic [W-1:0] a, b, c, s, m;
        assign a = in_ops[3*g];
        assign b = in_ops[3*g+1];
        assign c = in_ops[3*g+2];
        assign s = a ^ b ^ c;
        assign m = (a & b) | (a & c) | (b & c);
        assign out_ops[2*g]   = s;
        assign out_ops[2*g+1] = {m[W-2:0], 1'b0};

        // R1: each compressor keeps the modular sum of its three operands
        always_comb begin
            if (!$isunknown({a, b, c}))
                a_r1_csa_conserve: assert (W'(a + b + c) == W'(out_ops[2*g] + out_ops[2*g+1]))
                    else $error("compressor sum not conserved");
        end
    end

    for (genvar r = 0; r < REST; r++) begin : g_pass
        assign out_ops[2*GROUPS+r] = in_ops[3*GROUPS+r];
    end
endmodule

// File: rtl/ibd_final_add.sv
module ibd_final_add #(
    parameter int W = 7
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum
);
    assign sum = x + y + W'(cin);
endmodule

// File: rtl/ib_density_diff.sv
module ib_density_diff #(
    parameter int NBITS = ibd_pkg::DEF_BITS
) (
    input  logic [NBITS-1:0]          win_bits,
    input  logic [$clog2(NBITS+1)-1:0] limit,
    output logic [$clog2(NBITS+1):0]   delta,
    output logic                      over
);
    localparam int TW   = $clog2(NBITS + 1);
    localparam int W    = TW + 1;
    localparam int NOPS = NBITS + 1;
    localparam int ROWS = ibd_pkg::rows_for(NOPS);

    for (genvar l = 0; l <= ROWS; l++) begin : lvl
        localparam int NL = ibd_pkg::ops_at(NOPS, l);
        logic [W-1:0] ops [NL];
        if (l == 0) begin : g_load
            for (genvar i = 0; i < NBITS; i++) begin : g_bit
                assign ops[i] = {{(W-1){1'b0}}, win_bits[i]};
            end
            // inverted threshold; the +1 enters at the final adder
            assign ops[NBITS] = ~{1'b0, limit};
        end else begin : g_red
            ibd_csa_row #(
                .W    (W),
                .N_IN (ibd_pkg::ops_at(NOPS, l - 1)),
                .N_OUT(NL)
            ) u_row (
                .in_ops (lvl[l-1].ops),
                .out_ops(ops)
            );
        end
    end

    logic [W-1:0] root_sum;

    ibd_final_add #(.W(W)) u_cpa (
        .x  (lvl[ROWS].ops[0]),
        .y  (lvl[ROWS].ops[1]),
        .cin(1'b1),
        .sum(root_sum)
    );

    assign delta = root_sum;
    assign over  = ~root_sum[W-1] & (|root_sum[W-2:0]);

    always_comb begin
        if (!$isunknown({win_bits, limit})) begin
            // R3 / R5: an empty window gives exactly minus the limit
            if (win_bits == '0)
                a_r5_empty_window: assert ($signed(delta) == -$signed({1'b0, limit}))
                    else $error("empty window result wrong");
            // R4: a full window gives NBITS minus the limit
            if (win_bits == '1)
                a_r4_full_window: assert ($signed(delta) == $signed(W'(NBITS)) - $signed({1'b0, limit}))
                    else $error("full window result wrong");
            // R1: result stays inside the reachable range
            a_r1_range: assert ($signed(delta) >= -$signed({1'b0, limit}) &&
                                $signed(delta) <= $signed(W'(NBITS)) - $signed({1'b0, limit}))
                else $error("difference out of range");
            // R2: flag never set while the limit is not below the count bound
            if ({1'b0, limit} >= W'(NBITS))
                a_r2_no_flag_high_limit: assert (!over)
                    else $error("flag with unreachable limit");
        end
    end
endmodule

// File: tb/ib_density_diff_bench.sv
module ib_density_diff_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] win_bits = '0;
    logic [5:0]  limit = '0;
    logic [6:0]  delta;
    logic        over;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ib_density_diff u_ib_density_diff (
        .win_bits(win_bits),
        .limit   (limit),
        .delta   (delta),
        .over    (over)
    );

    task automatic check(input string req, input logic [31:0] w, input logic [5:0] t);
        int exp_d;
        bit exp_o;
        @(negedge clk);
        win_bits = w;
        limit    = t;
        #2;
        exp_d = $countones(w) - int'(t);
        exp_o = exp_d > 0;
        n_checks++;
        if ($signed(delta) != exp_d || over != exp_o) begin
            n_errors++;
            $display("FAIL %s w=%h t=%0d actual delta=%0d over=%0b expected delta=%0d over=%0b",
                     req, w, t, $signed(delta), over, exp_d, exp_o);
        end
    endtask

    task automatic t_reset_state();
        check("R3", 32'h0, 6'd0);
    endtask

    task automatic t_full();
        check("R4", 32'hFFFF_FFFF, 6'd0);
        check("R4", 32'hFFFF_FFFF, 6'd32);
        check("R2", 32'hFFFF_FFFF, 6'd31);
    endtask

    task automatic t_negative();
        check("R5", 32'h0, 6'd63);
        check("R5", 32'h0000_0003, 6'd40);
        check("R5", 32'h8000_0001, 6'd33);
    endtask

    task automatic t_single_bits();
        for (int i = 0; i < 32; i++) begin
            check("R7", 32'h1 << i, 6'd0);
            check("R7", 32'h1 << i, 6'd1);
        end
    endtask

    task automatic t_boundary();
        for (int k = 1; k <= 32; k++) begin
            logic [31:0] w;
            w = '0;
            for (int j = 0; j < k; j++) w[(j * 7) % 32] = 1'b1;
            check("R2", w, 6'(k));
            check("R2", w, 6'(k - 1));
        end
    endtask

    task automatic t_all_limits();
        for (int t = 0; t < 64; t++) begin
            for (int r = 0; r < 20; r++) check("R6", $urandom(), 6'(t));
            check("R1", 32'hA5A5_5A5A, 6'(t));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_full();
        t_negative();
        t_single_bits();
        t_boundary();
        t_all_limits();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule